// File: doc/BRIEF.md
# Port Control-Line Handshake Logic

This block runs the two control lines that go with one parallel I/O port. The first line, C1, is always an input. The second line, C2, can be an input or an output. A single bit in the control word picks which transition of C1 counts as active. A 3-bit field picks how C2 behaves:

- as an edge-watching input whose flag is cleared by a port data access;
- as an edge-watching input whose flag is left alone by port accesses;
- as a handshake output that drops on a port access and is released by the next active C1 transition;
- as a one-cycle strobe output;
- as a fixed low or high level.

The block turns line activity into two sticky interrupt flags, one per line. It also produces the C2 output level and its output enable. Both pad inputs pass through a synchronizer before edge detection.

The surrounding port logic does three things:
- It feeds in `port_rd` and `port_wr`, which are single-cycle strobes for reads and writes of the port data register.
- It feeds in `flag_clr`, which carries write-one-to-clear pulses from the flag register.
- It collects the flags for the interrupt controller.

The parameter `HS_WRITE_ONLY` selects the port variant whose handshake starts only on a write.

Top module: `port_ctl_lines`

## Requirements
- R1: After reset, `c1_flag` and `c2_flag` are 0, `c2_oe` is 0 and `c2_out` is 1.
- R2: `ctrl[0]` selects the active C1 transition: 0 means high-to-low and 1 means low-to-high. An active transition on `c1_in` sets `c1_flag` after three rising clock edges: two synchronizer stages and one flag register. The opposite transition leaves the flag at 0.
- R3: A `port_rd` or `port_wr` strobe clears `c1_flag`, and so does `flag_clr[1]`. `flag_clr[0]` does not affect `c1_flag`.
- R4: With C2 mode `ctrl[3:1]` = 000, a falling `c2_in` sets `c2_flag`. With 010, a rising `c2_in` sets it. The opposite transition does not set it. In both modes a port read or write clears the flag.
- R5: Modes 001 (falling) and 011 (rising) set `c2_flag` the same way, but a port access leaves the flag set. Only `flag_clr[0]` clears it.
- R6: In mode 100 (handshake), a triggering port access drives `c2_out` low from the next cycle on. It stays low until an active C1 transition. `c2_out` returns high on the same clock edge at which that transition sets `c1_flag`.
- R7: With `HS_WRITE_ONLY` = 0, both `port_rd` and `port_wr` start the handshake. With `HS_WRITE_ONLY` = 1, only `port_wr` starts it and a read leaves `c2_out` high.
- R8: In mode 101 (pulse), a single-cycle read or write strobe drives `c2_out` low for exactly one cycle, starting the cycle after the strobe. This holds for both values of `HS_WRITE_ONLY`.
- R9: Mode 110 holds `c2_out` low and mode 111 holds it high. `c2_oe` is 1 for modes 1xx and 0 for modes 0xx.
- R10: In the output modes (1xx), transitions on `c2_in` never set `c2_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctrl | input | 4 | bit 0: active C1 edge; bits 3:1: C2 mode |
| c1_in | input | 1 | C1 pad level |
| c2_in | input | 1 | C2 pad level when C2 is an input |
| port_rd | input | 1 | Single-cycle strobe for a read of the port data register |
| port_wr | input | 1 | Single-cycle strobe for a write of the port data register |
| flag_clr | input | 2 | Write-one-to-clear pulses: bit 1 clears the C1 flag, bit 0 clears the C2 flag |
| c1_flag | output | 1 | Sticky C1 transition flag |
| c2_flag | output | 1 | Sticky C2 transition flag |
| c2_out | output | 1 | C2 drive level |
| c2_oe | output | 1 | C2 output enable |

## Verification
The bench sweeps every combination of edge select and transition direction for C1. It sweeps all four C2 input modes in both directions, then reads the port and pulses the flag clear.

Two kinds of mistake show up in these sweeps:
- A design that swapped the edge polarity would set flags on the wrong transitions.
- A design that cleared the keep modes on an access would lose the flag after the read.

The handshake is driven through two instances, one of each port variant. A read must start the handshake on one and not on the other. Sampling one cycle before the C1 transition reaches the flag catches a release that comes early, skipping the synchronizer. Sampling the pulse mode in the cycle after the strobe and the cycle after that catches a strobe that is missing or stretched.

// File: rtl/hs_ctrl_pkg.sv
package hs_ctrl_pkg;

  typedef enum logic [2:0] {
    C2_IN_FALL      = 3'b000,
    C2_IN_FALL_KEEP = 3'b001,
    C2_IN_RISE      = 3'b010,
    C2_IN_RISE_KEEP = 3'b011,
    C2_HANDSHAKE    = 3'b100,
    C2_PULSE        = 3'b101,
    C2_DRIVE_LO     = 3'b110,
    C2_DRIVE_HI     = 3'b111
  } c2_mode_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/edge_pick.sv
module edge_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  output logic hit
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    if (rise_sel) hit = lvl & ~prev_q;
    else          hit = ~lvl & prev_q;
  end

endmodule

// File: rtl/c2_driver.sv
module c2_driver
  import hs_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  c2_mode_e mode,
  input  logic     access_any,
  input  logic     access_hs,
  input  logic     c1_hit,
  output logic     c2_out,
  output logic     c2_oe
);

  logic hs_low_q,    hs_low_d;
  logic pulse_low_q, pulse_low_d;
  logic hs_mode, pulse_mode;

  assign hs_mode    = (mode == C2_HANDSHAKE);
  assign pulse_mode = (mode == C2_PULSE);

  always_comb begin
    hs_low_d = hs_low_q;
    if (!hs_mode)       hs_low_d = 1'b0;
    else if (access_hs) hs_low_d = 1'b1;
    else if (c1_hit)    hs_low_d = 1'b0;
    pulse_low_d = pulse_mode & access_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_low_q    <= 1'b0;
      pulse_low_q <= 1'b0;
    end else begin
      hs_low_q    <= hs_low_d;
      pulse_low_q <= pulse_low_d;
    end
  end

  always_comb begin
    c2_oe = mode[2];
    unique case (mode)
      C2_HANDSHAKE: c2_out = ~hs_low_q;
      C2_PULSE:     c2_out = ~pulse_low_q;
      C2_DRIVE_LO:  c2_out = 1'b0;
      default:      c2_out = 1'b1;
    endcase
  end

  // R6: an active C1 edge without a new trigger releases the handshake
  p_hs_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode && c1_hit && !access_hs) |=> !hs_low_q);

  // R8: the strobe lasts one cycle unless a new access arrives
  p_pulse_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_low_q && !access_any) |=> !pulse_low_q);

endmodule

// File: rtl/port_ctl_lines.sv
module port_ctl_lines
  import hs_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter bit HS_WRITE_ONLY = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ctrl,
  input  logic       c1_in,
  input  logic       c2_in,
  input  logic       port_rd,
  input  logic       port_wr,
  input  logic [1:0] flag_clr,
  output logic       c1_flag,
  output logic       c2_flag,
  output logic       c2_out,
  output logic       c2_oe
);

  localparam int LINES = 2;

  c2_mode_e         mode;
  logic [LINES-1:0] lines_s;
  logic             c1_hit, c2_hit;
  logic             access_any, access_hs;
  logic             c2_is_in, c2_keep;
  logic             c1_flag_q, c1_flag_d;
  logic             c2_flag_q, c2_flag_d;

  assign mode       = c2_mode_e'(ctrl[3:1]);
  assign c2_is_in   = ~ctrl[3];
  assign c2_keep    = ctrl[1];
  assign access_any = port_rd | port_wr;

  generate
    if (HS_WRITE_ONLY) begin : g_hs_wr
      assign access_hs = port_wr;
    end else begin : g_hs_any
      assign access_hs = access_any;
    end
  endgenerate

  line_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({c2_in, c1_in}),
    .dout (lines_s)
  );

  edge_pick u_c1_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lines_s[0]),
    .rise_sel(ctrl[0]),
    .hit     (c1_hit)
  );

  edge_pick u_c2_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lines_s[1]),
    .rise_sel(ctrl[2]),
    .hit     (c2_hit)
  );

  // flag next state: a new edge takes priority over any clear
  always_comb begin
    c1_flag_d = c1_flag_q;
    if (c1_hit)                          c1_flag_d = 1'b1;
    else if (access_any || flag_clr[1])  c1_flag_d = 1'b0;

    c2_flag_d = c2_flag_q;
    if (c2_hit && c2_is_in)                          c2_flag_d = 1'b1;
    else if (flag_clr[0] || (access_any && !c2_keep)) c2_flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_flag_q <= 1'b0;
      c2_flag_q <= 1'b0;
    end else begin
      c1_flag_q <= c1_flag_d;
      c2_flag_q <= c2_flag_d;
    end
  end

  assign c1_flag = c1_flag_q;
  assign c2_flag = c2_flag_q;

  c2_driver u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .access_any(access_any),
    .access_hs (access_hs),
    .c1_hit    (c1_hit),
    .c2_out    (c2_out),
    .c2_oe     (c2_oe)
  );

  // R2: an active C1 edge always lands in the flag
  p_c1_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c1_hit |=> c1_flag);

  // R3: a port access without a simultaneous edge clears the C1 flag
  p_c1_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_flag && access_any && !c1_hit) |=> !c1_flag);

  // R5: keep modes hold the C2 flag until the explicit clear
  p_c2_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c2_flag && c2_is_in && c2_keep && !flag_clr[0]) |=> c2_flag);

  // R10: output modes never raise the C2 flag
  p_out_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!c2_is_in && !c2_flag) |=> !c2_flag);

endmodule

// File: tb/port_ctl_lines_test.sv
module port_ctl_lines_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ctrl;
  logic       c1_in, c2_in, port_rd, port_wr;
  logic [1:0] flag_clr;
  logic       c1_flag, c2_flag, c2_out, c2_oe;
  logic       b_c1_flag, b_c2_flag, b_c2_out, b_c2_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  port_ctl_lines #(.SYNC_STAGES(2), .HS_WRITE_ONLY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .c1_in(c1_in), .c2_in(c2_in),
    .port_rd(port_rd), .port_wr(port_wr), .flag_clr(flag_clr),
    .c1_flag(c1_flag), .c2_flag(c2_flag), .c2_out(c2_out), .c2_oe(c2_oe));

  port_ctl_lines #(.SYNC_STAGES(2), .HS_WRITE_ONLY(1'b1)) uut_b (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .c1_in(c1_in), .c2_in(c2_in),
    .port_rd(port_rd), .port_wr(port_wr), .flag_clr(flag_clr),
    .c1_flag(b_c1_flag), .c2_flag(b_c2_flag), .c2_out(b_c2_out), .c2_oe(b_c2_oe));

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic pulse_clr(input logic [1:0] v);
    flag_clr = v;
    cyc(1);
    flag_clr = 2'b00;
  endtask

  task automatic do_rd();
    port_rd = 1'b1;
    cyc(1);
    port_rd = 1'b0;
  endtask

  task automatic do_wr();
    port_wr = 1'b1;
    cyc(1);
    port_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ctrl = 4'b0000; c1_in = 1'b0; c2_in = 1'b0;
    port_rd = 1'b0; port_wr = 1'b0; flag_clr = 2'b00;
    cyc(3);
    chk("R1 c2_oe in reset", c2_oe, 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 c1_flag", c1_flag, 0);
    chk("R1 c2_flag", c2_flag, 0);
    chk("R1 c2_oe", c2_oe, 0);
    chk("R1 c2_out", c2_out, 1);

    // R2: C1 edge select sweep
    for (int sel = 0; sel < 2; sel++) begin
      for (int rise = 0; rise < 2; rise++) begin
        ctrl  = {3'b000, sel[0]};
        c1_in = ~rise[0];
        cyc(4);
        pulse_clr(2'b10);
        chk("R2 idle flag", c1_flag, 0);
        c1_in = rise[0];
        cyc(2);
        chk("R2 before sync latency", c1_flag, 0);
        cyc(1);
        chk("R2 edge select", c1_flag, (sel == rise) ? 8'd1 : 8'd0);
      end
    end

    // R3: clear sources for the C1 flag
    ctrl = 4'b0001; c1_in = 1'b0; cyc(4);
    c1_in = 1'b1; cyc(3);
    chk("R3 setup flag", c1_flag, 1);
    pulse_clr(2'b01);
    chk("R3 C2 clear ignored by C1", c1_flag, 1);
    do_wr();
    chk("R3 write clears", c1_flag, 0);
    c1_in = 1'b0; cyc(4); c1_in = 1'b1; cyc(3);
    do_rd();
    chk("R3 read clears", c1_flag, 0);
    c1_in = 1'b0; cyc(4); c1_in = 1'b1; cyc(3);
    pulse_clr(2'b10);
    chk("R3 flag_clr clears", c1_flag, 0);

    // R4 / R5: C2 input mode sweep
    for (int m = 0; m < 4; m++) begin
      for (int rise = 0; rise < 2; rise++) begin
        ctrl  = {m[2:0], 1'b1};
        c2_in = ~rise[0];
        cyc(4);
        pulse_clr(2'b01);
        chk("R4 idle flag", c2_flag, 0);
        chk("R4 oe low in input mode", c2_oe, 0);
        c2_in = rise[0];
        cyc(3);
        if (m[1] == rise[0]) begin
          chk("R4 active edge sets", c2_flag, 1);
          do_rd();
          if (m[0]) chk("R5 access keeps flag", c2_flag, 1);
          else      chk("R4 access clears flag", c2_flag, 0);
          pulse_clr(2'b01);
          chk("R5 flag_clr clears", c2_flag, 0);
        end else begin
          chk("R4 opposite edge ignored", c2_flag, 0);
        end
      end
    end

    // R9 / R10: manual drive modes
    for (int v = 0; v < 2; v++) begin
      ctrl = {2'b11, v[0], 1'b1};
      c2_in = 1'b1; cyc(4); c2_in = 1'b0; cyc(4); c2_in = 1'b1; cyc(4);
      chk("R9 oe in drive mode", c2_oe, 1);
      chk("R9 drive level", c2_out, v[0]);
      chk("R10 no flag in output mode", c2_flag, 0);
    end

    // R6 / R7: handshake
    ctrl = 4'b1001; c1_in = 1'b0; cyc(4);
    chk("R6 idle high", c2_out, 1);
    chk("R9 oe in handshake", c2_oe, 1);
    c2_in = 1'b0; cyc(4);
    chk("R10 no flag in handshake", c2_flag, 0);
    do_rd();
    chk("R7 read starts handshake", c2_out, 0);
    chk("R7 write-only ignores read", b_c2_out, 1);
    cyc(2);
    chk("R6 stays low", c2_out, 0);
    do_wr();
    chk("R7 write starts handshake", b_c2_out, 0);
    c1_in = 1'b1; cyc(2);
    chk("R6 low before edge reaches", c2_out, 0);
    chk("R6 b low before edge reaches", b_c2_out, 0);
    cyc(1);
    chk("R6 release", c2_out, 1);
    chk("R6 b release", b_c2_out, 1);
    chk("R6 flag with release", c1_flag, 1);
    do_wr();
    c1_in = 1'b0; cyc(4);
    chk("R6 wrong edge keeps low", c2_out, 0);

    // R8: pulse
    ctrl = 4'b1011; cyc(2);
    chk("R8 idle high", c2_out, 1);
    do_rd();
    chk("R8 read pulse low", c2_out, 0);
    chk("R8 b read pulse low", b_c2_out, 0);
    cyc(1);
    chk("R8 pulse ends", c2_out, 1);
    chk("R8 b pulse ends", b_c2_out, 1);
    do_wr();
    chk("R8 write pulse low", c2_out, 0);
    cyc(1);
    chk("R8 write pulse ends", c2_out, 1);

    finish_run();
  end

endmodule